// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address that a synchronous burst memory core uses in each cycle. When either of two address strobes is asserted, it captures a full external address. From then on it steps through the four words that share the captured upper address bits. It takes one step on each cycle in which the advance input is high, and it keeps the current word on each cycle in which that input is low. The upper bits always pass through unchanged from the captured address.

Two counting orders are available. Linear order counts the two low bits upward from the captured value and wraps modulo four. Interleaved order XORs the captured low bits with a running step count of 0, 1, 2, 3. The order input is sampled together with the address, so a change to it in the middle of a burst has no effect until the next load. Bursting is optional: a new address may be loaded on any cycle, and a load overrides an advance in the same cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active, and on the first cycle after it, `arr_addr_o` is all zeros.
- R2: A cycle with `strobe_cpu_i` or `strobe_ctl_i` high (either one or both) loads `addr_i`, and `arr_addr_o` equals that address from the next clock edge onward.
- R3: With linear order captured, after k advances since the load, the low two bits of `arr_addr_o` equal (loaded low bits + k) mod 4, and they keep wrapping past four steps.
- R4: With interleaved order captured, after k advances since the load, the low two bits of `arr_addr_o` equal (loaded low bits) XOR (k mod 4).
- R5: `order_lin_i` = 1 selects linear order and 0 selects interleaved order, which is the default and inactive level. The order is sampled only in a load cycle, and changes to it at other times leave `arr_addr_o` unaffected.
- R6: A cycle with no strobe and `adv_i` low leaves `arr_addr_o` unchanged.
- R7: When a strobe and `adv_i` are high in the same cycle, the load wins and no step is taken.
- R8: The upper AW-2 bits of `arr_addr_o` change only on a load.
- R9: A load in the middle of a burst restarts the sequence from the new address at step zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | AW | External address to be loaded |
| strobe_cpu_i | input | 1 | Processor-side address strobe |
| strobe_ctl_i | input | 1 | Controller-side address strobe |
| adv_i | input | 1 | Advance the burst by one word |
| order_lin_i | input | 1 | 1 = linear order, 0 = interleaved order |
| arr_addr_o | output | AW | Current address to the memory core |

## Verification
The assertions assume that every input is a known 0 or 1 at each clock edge. They also assume that a step is measured from the most recent load, or from reset, which acts as a load of address zero in interleaved order. The bench keeps within these assumptions. It drives every input to a defined value half a cycle ahead of each edge, and it begins each burst with an explicit strobe before it counts any advances. It sweeps all four starting offsets in both orders. Along the way it mixes hold cycles, combined strobe-and-advance cycles, order toggles in mid-burst and reloads in mid-burst.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_STEP = 2'd1,
    CMD_LOAD = 2'd2
  } seq_cmd_e;

  // Linear order: offset counts upward from the start word, modulo four.
  function automatic logic [BURST_W-1:0] lin_word(input logic [BURST_W-1:0] start,
                                                  input logic [BURST_W-1:0] step);
    return start + step;
  endfunction

  // Interleaved order: start word with its bits flipped by the step count.
  function automatic logic [BURST_W-1:0] ilv_word(input logic [BURST_W-1:0] start,
                                                  input logic [BURST_W-1:0] step);
    return start ^ step;
  endfunction
endpackage

// File: rtl/seq_cmd_decode.sv
module seq_cmd_decode
  import burst_addr_pkg::*;
(
  input  logic     strobe_cpu_i,
  input  logic     strobe_ctl_i,
  input  logic     adv_i,
  output seq_cmd_e cmd_o
);
  always_comb begin
    if (strobe_cpu_i || strobe_ctl_i) cmd_o = CMD_LOAD;
    else if (adv_i)                   cmd_o = CMD_STEP;
    else                              cmd_o = CMD_HOLD;
  end
endmodule

// File: rtl/seq_step_counter.sv
module seq_step_counter
  import burst_addr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  seq_cmd_e           cmd_i,
  output logic [BURST_W-1:0] step_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 step_o <= '0;
    else if (cmd_i == CMD_LOAD) step_o <= '0;
    else if (cmd_i == CMD_STEP) step_o <= step_o + 1'b1;
  end

  // R9: a load restarts the step count
  a_r9_load_clears_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_LOAD) |=> (step_o == '0));
  // R3/R4: one advance moves the count by one, wrapping
  a_r3_step_increments: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_STEP) |=> (step_o == $past(step_o) + 2'd1));
  // R6: no strobe and no advance keeps the count
  a_r6_step_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_HOLD) |=> $stable(step_o));
endmodule

// File: rtl/seq_base_reg.sv
module seq_base_reg
  import burst_addr_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_cmd_e      cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic          order_lin_i,
  output logic [AW-1:0] base_o,
  output logic          lin_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o <= '0;
      lin_o  <= 1'b0;
    end else if (cmd_i == CMD_LOAD) begin
      base_o <= addr_i;
      lin_o  <= order_lin_i;
    end
  end

  // R8: captured address only changes on load
  a_r8_base_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i != CMD_LOAD) |=> $stable(base_o));
  // R5: order is captured only on load
  a_r5_order_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i != CMD_LOAD) |=> $stable(lin_o));
endmodule

// File: rtl/seq_order_map.sv
module seq_order_map
  import burst_addr_pkg::*;
(
  input  logic [BURST_W-1:0] start_i,
  input  logic [BURST_W-1:0] step_i,
  input  logic               lin_i,
  output logic [BURST_W-1:0] word_o
);
  always_comb word_o = lin_i ? lin_word(start_i, step_i) : ilv_word(start_i, step_i);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_addr_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          strobe_cpu_i,
  input  logic          strobe_ctl_i,
  input  logic          adv_i,
  input  logic          order_lin_i,
  output logic [AW-1:0] arr_addr_o
);
  localparam int UW = AW - BURST_W;

  seq_cmd_e           cmd;
  logic [BURST_W-1:0] step;
  logic [AW-1:0]      base;
  logic               lin_sel;
  logic [BURST_W-1:0] word;

  // named events for the checks below
  logic ev_load, ev_hold, ev_load_adv;
  assign ev_load     = (cmd == CMD_LOAD);
  assign ev_hold     = (cmd == CMD_HOLD);
  assign ev_load_adv = ev_load && adv_i;

  seq_cmd_decode u_dec (
    .strobe_cpu_i (strobe_cpu_i),
    .strobe_ctl_i (strobe_ctl_i),
    .adv_i        (adv_i),
    .cmd_o        (cmd)
  );

  seq_step_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_i  (cmd),
    .step_o (step)
  );

  seq_base_reg #(.AW(AW)) u_base (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd),
    .addr_i      (addr_i),
    .order_lin_i (order_lin_i),
    .base_o      (base),
    .lin_o       (lin_sel)
  );

  seq_order_map u_map (
    .start_i (base[BURST_W-1:0]),
    .step_i  (step),
    .lin_i   (lin_sel),
    .word_o  (word)
  );

  assign arr_addr_o = {base[AW-1:BURST_W], word};

  // R2: loaded address appears after the edge
  a_r2_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> (arr_addr_o == $past(addr_i)));
  // R7: strobe beats advance
  a_r7_strobe_priority: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_adv |=> (arr_addr_o == $past(addr_i)));
  // R6: hold keeps the output address
  a_r6_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> $stable(arr_addr_o));
  // R8: upper bits pass unchanged between loads
  a_r8_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_load |=> $stable(arr_addr_o[AW-1:BURST_W]));
  // R1: reset clears the output
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (arr_addr_o == '0));
  initial assert (UW > 0);
endmodule

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          strobe_cpu_i = 1'b0, strobe_ctl_i = 1'b0, adv_i = 1'b0, order_lin_i = 1'b0;
  logic [AW-1:0] arr_addr_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .strobe_cpu_i(strobe_cpu_i), .strobe_ctl_i(strobe_ctl_i),
    .adv_i(adv_i), .order_lin_i(order_lin_i), .arr_addr_o(arr_addr_o)
  );

  // bench model of the burst state
  logic [AW-1:0] m_base;
  int            m_k;
  bit            m_lin;

  function automatic logic [AW-1:0] model_addr();
    int lo = m_base % 4;
    int w;
    if (m_lin) w = (lo + m_k) % 4;
    else       w = lo ^ (m_k % 4);
    return (m_base / 4) * 4 + w;
  endfunction

  task automatic check(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // apply inputs before an edge, sample 1 ns after it
  task automatic cyc(bit s_cpu, bit s_ctl, bit adv, bit ord, logic [AW-1:0] a);
    @(negedge clk);
    strobe_cpu_i = s_cpu; strobe_ctl_i = s_ctl; adv_i = adv;
    order_lin_i = ord; addr_i = a;
    @(posedge clk);
    #1;
    if (s_cpu || s_ctl) begin m_base = a; m_k = 0; m_lin = ord; end
    else if (adv) m_k++;
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    // R1 reset state
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", arr_addr_o, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check("R1 after reset", arr_addr_o, '0);

    // sweep both orders and all four start offsets
    for (int ord = 0; ord < 2; ord++) begin
      for (int off = 0; off < 4; off++) begin
        a = AW'((32'h5A3C4 + off * 32'h1110 + ord * 32'h2222) & 32'hFFFFC) | AW'(off);
        if (off[0]) cyc(0, 1, 0, ord[0], a);
        else        cyc(1, 0, 0, ord[0], a);
        check("R2 load", arr_addr_o, model_addr());
        for (int s = 0; s < 6; s++) begin
          cyc(0, 0, 1, ~ord[0], '1);  // R5 order toggled mid-burst ignored
          check(ord ? "R3 linear step" : "R4 interleaved step", arr_addr_o, model_addr());
          check("R8 upper bits", {arr_addr_o[AW-1:2], 2'b00}, {a[AW-1:2], 2'b00});
          if (s == 2) begin
            cyc(0, 0, 0, ord[0], '0);
            check("R6 hold", arr_addr_o, model_addr());
          end
        end
      end
    end

    // R7 strobe with advance: load wins
    cyc(1, 0, 0, 1, 20'h00011);
    cyc(0, 0, 1, 1, 20'h0);
    cyc(1, 0, 1, 0, 20'hABCD2);
    check("R7 priority", arr_addr_o, 20'hABCD2);
    cyc(0, 0, 1, 1, 20'h0);
    check("R5 interleaved default", arr_addr_o, 20'hABCD3);
    // both strobes together
    cyc(1, 1, 0, 1, 20'h12343);
    check("R2 both strobes", arr_addr_o, 20'h12343);
    cyc(0, 0, 1, 0, 20'h0);
    check("R3 linear wrap", arr_addr_o, 20'h12340);
    // R9 reload mid-burst
    cyc(0, 0, 1, 0, 20'h0);
    cyc(0, 1, 0, 0, 20'hFFFF1);
    check("R9 reload", arr_addr_o, 20'hFFFF1);
    cyc(0, 0, 1, 1, 20'h0);
    check("R9 restart step", arr_addr_o, 20'hFFFF0);
    cyc(0, 0, 1, 1, 20'h0);
    check("R4 after reload", arr_addr_o, model_addr());

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule